// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block sits behind a bit-level demodulator and line decoder. It takes one recovered bit per strobe and turns the stream back into bytes. It looks for the flag pattern to find frame boundaries. It drops the zero that a transmitter inserts after five ones in a row. It stops receiving when it sees an abort run. The output is a byte stream with a one-cycle valid pulse. Flags travel in-band as raw `0x7E` bytes. A data byte that happens to equal the flag (`0x7E`), the abort value (`0x7F`) or the escape value (`0x1B`) goes out with the escape byte `0x1B` in front of it. A later stage can therefore tell framing apart from data without a side channel. CRC checking and address parsing belong to later stages.

Every strobe shifts the new bit into the low end of an 8-bit history register. A three-state machine steers everything else:

- **HUNT**: waits for a flag and ignores all other bits.
- **RECV**: assembles data bytes least significant bit first.
- **PEND**: exists only for one cycle after an escape byte, to send the data byte it protects.

The transitions are:

- **flag-accepted**: HUNT/RECV → RECV.
- **flag-refused**: HUNT/RECV → HUNT, taken when the output is full at the flag.
- **abort**: RECV → HUNT.
- **drop**: RECV → HUNT, taken when the output is full for a completed byte.
- **collide**: RECV → PEND.
- **resume**: PEND → RECV.
- **quit**: PEND → HUNT, taken when either byte of the escape pair could not be sent.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `byte_valid` is low. The history register clears to zero and the machine starts in HUNT.
- R2: When the eight most recent bits, oldest first, read `01111110`, the block emits `0x7E` in the cycle after that strobe if `out_full` is low. It then enters RECV with the byte assembler and bit counter cleared. This holds in HUNT and in RECV.
- R3: In HUNT, every bit that does not complete a flag produces no output.
- R4: In RECV, each kept bit enters the assembler at the MSB while the assembler shifts right, so bytes arrive least significant bit first. The eighth kept bit completes a byte, which goes out in the cycle after that strobe.
- R5: In RECV, a `0` that directly follows five `1`s is dropped and does not count towards a byte. A sixth `1` is kept.
- R6: In RECV, seven consecutive `1`s return the machine to HUNT. Nothing more is emitted until the next flag.
- R7: A completed byte equal to `0x7E`, `0x7F` or `0x1B` goes out as `0x1B` followed by the byte itself, on two consecutive cycles.
- R8: When `out_full` is high at the moment a byte would be emitted, that byte is lost. A refused flag or data byte leaves the machine in HUNT. A refused escape byte still lets its data byte try to go out, after which the machine is in HUNT.
- R9: `byte_valid` is raised only in the cycle after a bit strobe or after a PEND cycle. Strobes must be at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe marking a new received bit |
| bit_in | input | 1 | Received bit value |
| out_full | input | 1 | Downstream cannot take a byte this cycle |
| byte_valid | output | 1 | One-cycle pulse marking `byte_out` valid |
| byte_out | output | 8 | Flag, escape or data byte |

## Verification
A stale history register shows up at the ports as a missing or spurious `0x7E`, within eight strobes of the fault. A bit counter that is out of step garbles every following byte of the frame until the next flag realigns it. A machine stuck in HUNT after a refused byte, or left in RECV after an abort, shows up as missing or extra bytes before the closing flag. A bad PEND handoff shows up as an escape byte that is not followed, one cycle later, by its data byte.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_RECV = 2'd1,
        S_PEND = 2'd2
    } rx_state_e;

endpackage

// File: rtl/hdlc_rx_hist.sv
// Bit history shift register and line-pattern decoders.
module hdlc_rx_hist #(
    parameter int            W         = 8,
    parameter logic [W-1:0]  FLAG_VAL  = 8'h7E,
    parameter logic [W-1:0]  ABORT_VAL = 8'h7F,
    parameter int            STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic is_flag,
    output logic is_abort,
    output logic is_stuff
);
    localparam int                 PAT_W     = STUFF_RUN + 1;
    localparam logic [PAT_W-1:0]   STUFF_PAT = {{STUFF_RUN{1'b1}}, 1'b0};

    logic [W-1:0] hist_q;
    logic [W-1:0] hist_nx;

    assign hist_nx  = {hist_q[W-2:0], bit_in};
    assign is_flag  = (hist_nx == FLAG_VAL);
    assign is_abort = ((hist_nx & ABORT_VAL) == ABORT_VAL);
    assign is_stuff = (hist_nx[PAT_W-1:0] == STUFF_PAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_nx;
        end
    end

endmodule

// File: rtl/hdlc_rx_asm.sv
// Byte assembler: LSB-first, new bit enters at the MSB.
module hdlc_rx_asm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] byte_nx,
    output logic         done
);
    localparam int                CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(W - 1);

    logic [W-1:0]     data_q;
    logic [CNT_W-1:0] cnt_q;

    assign byte_nx = {bit_in, data_q[W-1:1]};
    assign done    = shift_en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (clr || done) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            data_q <= byte_nx;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FLAG_VAL  = 8'h7E,
    parameter logic [BYTE_W-1:0] ABORT_VAL = 8'h7F,
    parameter logic [BYTE_W-1:0] ESC_VAL   = 8'h1B,
    parameter int                STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              out_full,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out
);
    rx_state_e          state_q, state_d;
    logic [BYTE_W-1:0]  pend_q, pend_d;
    logic               resume_q, resume_d;
    logic               emit;
    logic [BYTE_W-1:0]  emit_val;
    logic               asm_clr, asm_shift, asm_done;
    logic [BYTE_W-1:0]  asm_byte;
    logic               is_flag, is_abort, is_stuff;
    logic               byte_is_ctrl;

    hdlc_rx_hist #(
        .W         (BYTE_W),
        .FLAG_VAL  (FLAG_VAL),
        .ABORT_VAL (ABORT_VAL),
        .STUFF_RUN (STUFF_RUN)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_valid),
        .bit_in   (bit_in),
        .is_flag  (is_flag),
        .is_abort (is_abort),
        .is_stuff (is_stuff)
    );

    hdlc_rx_asm #(
        .W (BYTE_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (asm_clr),
        .shift_en (asm_shift),
        .bit_in   (bit_in),
        .byte_nx  (asm_byte),
        .done     (asm_done)
    );

    assign byte_is_ctrl = (asm_byte == FLAG_VAL) ||
                          (asm_byte == ABORT_VAL) ||
                          (asm_byte == ESC_VAL);

    // Next-state and emission decision
    always_comb begin
        state_d   = state_q;
        pend_d    = pend_q;
        resume_d  = resume_q;
        emit      = 1'b0;
        emit_val  = '0;
        asm_clr   = 1'b0;
        asm_shift = 1'b0;
        unique case (state_q)
            S_HUNT, S_RECV: begin
                if (bit_valid) begin
                    if (is_flag) begin
                        if (!out_full) begin          // flag-accepted
                            emit     = 1'b1;
                            emit_val = FLAG_VAL;
                            asm_clr  = 1'b1;
                            state_d  = S_RECV;
                        end else begin                // flag-refused
                            state_d  = S_HUNT;
                        end
                    end else if (state_q == S_RECV) begin
                        if (is_abort) begin           // abort
                            state_d = S_HUNT;
                        end else if (!is_stuff) begin
                            asm_shift = 1'b1;
                            if (asm_done) begin
                                if (byte_is_ctrl) begin   // collide
                                    pend_d   = asm_byte;
                                    resume_d = !out_full;
                                    state_d  = S_PEND;
                                    if (!out_full) begin
                                        emit     = 1'b1;
                                        emit_val = ESC_VAL;
                                    end
                                end else if (!out_full) begin
                                    emit     = 1'b1;
                                    emit_val = asm_byte;
                                end else begin            // drop
                                    state_d = S_HUNT;
                                end
                            end
                        end
                    end
                end
            end
            S_PEND: begin
                if (!out_full) begin
                    emit     = 1'b1;
                    emit_val = pend_q;
                    state_d  = resume_q ? S_RECV : S_HUNT;  // resume / quit
                end else begin
                    state_d  = S_HUNT;                       // quit
                end
            end
            default: state_d = S_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_HUNT;
            pend_q   <= '0;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            pend_q   <= pend_d;
            resume_q <= resume_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_out   <= '0;
        end else begin
            byte_valid <= emit;
            if (emit) begin
                byte_out <= emit_val;
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
    import hdlc_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FLAG_VAL  = 8'h7E,
    parameter logic [BYTE_W-1:0] ABORT_VAL = 8'h7F,
    parameter logic [BYTE_W-1:0] ESC_VAL   = 8'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              out_full,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_out,
    input  rx_state_e         state_q
);
    // R1: reset holds the output quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !byte_valid);

    // R2: a flag emitted straight from a strobe means reception has started
    p_flag_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_out == FLAG_VAL && $past(bit_valid)) |-> state_q == S_RECV);

    // R7: an accepted escape prefix is followed next cycle by its control byte
    p_esc_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_out == ESC_VAL && $past(bit_valid) && !out_full)
        |=> (byte_valid && (byte_out == FLAG_VAL || byte_out == ABORT_VAL || byte_out == ESC_VAL)));

    // R8: nothing is emitted against a full output
    p_no_emit_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |=> !byte_valid);

    // R9: every output pulse has a cause one cycle earlier
    p_valid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> ($past(bit_valid) || $past(state_q) == S_PEND));

    // R9: strobe spacing leaves the PEND cycle free
    p_pend_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_PEND |-> !bit_valid);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(
    .FLAG_VAL  (FLAG_VAL),
    .ABORT_VAL (ABORT_VAL),
    .ESC_VAL   (ESC_VAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .out_full   (out_full),
    .byte_valid (byte_valid),
    .byte_out   (byte_out),
    .state_q    (state_q)
);

// File: tb/hdlc_rx_deframer_test.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_test;

    localparam logic [7:0] FLAG = 8'h7E;
    localparam logic [7:0] ABRT = 8'h7F;
    localparam logic [7:0] ESC  = 8'h1B;
    localparam int NF = 6;
    localparam logic [7:0] PAY [0:NF-1][0:2] = '{
        '{8'h41, 8'h42, 8'h43},
        '{8'h7E, 8'h00, 8'hA5},
        '{8'hFF, 8'h1F, 8'hF8},
        '{8'h7F, 8'h1B, 8'h3C},
        '{8'h80, 8'h01, 8'hFE},
        '{8'h1B, 8'h1B, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic out_full = 1'b0;
    logic byte_valid;
    logic [7:0] byte_out;

    int errors = 0;
    int checks = 0;
    int ones = 0;
    int cyc = 0;
    int cap_n = 0;
    int cap [0:255];
    int capc [0:255];
    int exp_n = 0;
    int expv [0:63];
    bit escm [0:63];
    bit finished = 0;

    always #2 clk = ~clk;

    hdlc_rx_deframer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .out_full   (out_full),
        .byte_valid (byte_valid),
        .byte_out   (byte_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && byte_valid && cap_n < 256) begin
            cap[cap_n]  = int'(byte_out);
            capc[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int ex, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, ex);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(FLAG);
        ones = 0;
    endtask

    task automatic send_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            ones = v[i] ? ones + 1 : 0;
            if (ones == 5) begin
                send_bit(1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input bit is_esc);
        expv[exp_n] = int'(v);
        escm[exp_n] = is_esc;
        exp_n++;
    endtask

    task automatic push_data(input logic [7:0] v);
        if (v == FLAG || v == ABRT || v == ESC) push_exp(ESC, 1'b1);
        push_exp(v, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_frame(input string req);
        chk(cap_n == exp_n, req, cap_n, exp_n, "byte count");
        for (int i = 0; i < exp_n && i < cap_n; i++)
            chk(cap[i] == expv[i], req, cap[i], expv[i], $sformatf("byte %0d", i));
        for (int i = 0; i + 1 < exp_n && i + 1 < cap_n; i++)
            if (escm[i])
                chk(capc[i+1] == capc[i] + 1, "R7/R9 pair spacing", capc[i+1] - capc[i], 1, "cycles");
    endtask

    task automatic start_case();
        cap_n = 0;
        exp_n = 0;
    endtask

    initial begin
        #(4 * 120000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        chk(byte_valid == 1'b0, "R1 in reset", byte_valid, 0, "byte_valid");
        rst_n = 1'b1;
        @(negedge clk);
        chk(byte_valid == 1'b0, "R1 after reset", byte_valid, 0, "byte_valid");

        // R3: hunting ignores non-flag bits
        start_case();
        send_raw(8'h55);
        send_raw(8'hFF);
        send_raw(8'h34);
        idle(4);
        chk(cap_n == 0, "R3 hunt silence", cap_n, 0, "byte count");

        // R6: abort stops reception until next flag
        start_case();
        send_flag();
        send_stuffed(8'h12);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_raw(8'h00);
        send_raw(8'h34);
        idle(4);
        push_exp(FLAG, 1'b0);
        push_exp(8'h12, 1'b0);
        check_frame("R6 abort");

        // R2/R4/R5/R7: table of frames
        for (int f = 0; f < NF; f++) begin
            start_case();
            push_exp(FLAG, 1'b0);
            for (int k = 0; k < 3; k++) push_data(PAY[f][k]);
            push_exp(FLAG, 1'b0);
            send_flag();
            for (int k = 0; k < 3; k++) send_stuffed(PAY[f][k]);
            send_flag();
            idle(4);
            check_frame($sformatf("R2/R4/R5/R7 frame %0d", f));
        end

        // R8: data byte refused, reception stops
        start_case();
        send_flag();
        out_full = 1'b1;
        send_stuffed(8'h5A);
        out_full = 1'b0;
        send_stuffed(8'h33);
        send_flag();
        idle(4);
        push_exp(FLAG, 1'b0);
        push_exp(FLAG, 1'b0);
        check_frame("R8 data refused");

        // R8: opening flag refused, stays hunting
        start_case();
        out_full = 1'b1;
        send_flag();
        out_full = 1'b0;
        send_stuffed(8'h21);
        send_flag();
        idle(4);
        push_exp(FLAG, 1'b0);
        check_frame("R8 flag refused");

        // R8: escape pair refused
        start_case();
        send_flag();
        out_full = 1'b1;
        send_stuffed(8'h7E);
        idle(2);
        out_full = 1'b0;
        send_stuffed(8'h44);
        send_flag();
        idle(4);
        push_exp(FLAG, 1'b0);
        push_exp(FLAG, 1'b0);
        check_frame("R8 escape refused");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule